// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block is the cache controller for one processor on a shared snooping bus. It holds a small direct-mapped array of one-word lines and uses a write-back policy. Each line is in one of three states, encoded as 2'b00 Invalid, 2'b01 Shared and 2'b10 Modified. Shared means clean and possibly held by other caches. Modified means dirty and held by this cache alone. The processor side presents a request with a write flag, an address and write data. It holds the request until `cpu_ready` pulses, and read data is valid in that same cycle.

On the bus side the controller raises `bus_req` toward an external arbiter and drives a command, an address and write-back data. A transaction takes effect in the single cycle in which `bus_gnt` is high. A read-miss fill arrives on `bus_rdata` in that same cycle. Transactions from other caches arrive on the snoop inputs. Every snooped address is compared against the tags. The controller drops a line when another cache announces an invalidate for it. When a snooped read miss finds a dirty line here, the controller returns the word itself and tells memory to stay silent.

Top module: `snoop_cache`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address requests the bus. With no request and no snoop, `cpu_ready`, `bus_req`, `snp_supply` and `mem_abort` are all low.
- R2: A read miss requests the bus with command 2'b01 at the requested address. In the grant cycle the word on `bus_rdata` is returned with `cpu_ready`, and the line becomes Shared. Later reads of that address complete in their first cycle without a bus request.
- R3: A write to a Shared line requests the bus with command 2'b10 at the write address. It completes only in the grant cycle, after which the line holds the new word as Modified.
- R4: A write to a Modified line completes in its first cycle and issues no bus transaction.
- R5: A write miss issues a read miss (2'b01) and then an invalidate (2'b10), both at the write address, and leaves the line Modified with the written word.
- R6: A miss whose victim line is Modified first writes the victim back with command 2'b11, the victim's address and its word. Only then does it issue the read miss for the new address.
- R7: A snooped invalidate (2'b10) to a held address clears that line. The next read of it misses and fetches the fresh word over the bus.
- R8: A snooped read miss (2'b01) to a Modified line raises `snp_supply` and `mem_abort` in that cycle and drives the line's word on `snp_data`. The line becomes Shared, so the next local write must invalidate over the bus.
- R9: A snooped read miss to a Shared line leaves `snp_supply` and `mem_abort` low and changes nothing.
- R10: A snoop to the same index with a different tag leaves the held line untouched.
- R11: Suppose a pending write to a Shared line loses the bus to another cache's invalidate of the same address. The controller then issues a read miss and then its own invalidate, and the write's value is what later reads return.
- R12: While `snp_valid` is high, `cpu_ready` stays low. A hit presented in a snoop cycle completes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_cmd | output | 2 | 01 read miss, 10 invalidate, 11 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back word |
| bus_rdata | input | DATA_W | Fill word in the read-miss grant cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_supply | output | 1 | This cache drives the snooped word |
| snp_data | output | DATA_W | Word supplied on a dirty snoop hit |
| mem_abort | output | 1 | Memory must not answer this read miss |

## Verification
The assertions rely on the following input rules. `bus_gnt` is high only while `bus_req` is high and never in a cycle with `snp_valid`. Snooped transactions never come from this cache. The processor keeps its request steady until `cpu_ready`. The bench's arbiter derives the grant from `bus_req` gated by an enable and by `snp_valid`, so these rules hold even in the contention case, where the grant is withheld while another cache's invalidate goes by. Snoops of another cache's writes also update the bench memory, so a re-fetch returns the other cache's value.

// File: rtl/snc_pkg.sv
package snc_pkg;
   typedef enum logic [1:0] {
      ST_INV = 2'b00,
      ST_SHR = 2'b01,
      ST_MOD = 2'b10
   } line_st_t;

   typedef enum logic [1:0] {
      CMD_IDLE   = 2'b00,
      CMD_RDMISS = 2'b01,
      CMD_INVAL  = 2'b10,
      CMD_WBACK  = 2'b11
   } bus_cmd_t;
endpackage

// File: rtl/snc_array.sv
module snc_array
   import snc_pkg::*;
#(
   parameter int INDEX_W = 2,
   parameter int TAG_W   = 14,
   parameter int DATA_W  = 32,
   localparam int LINES  = 1 << INDEX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd_en,
   input  logic [INDEX_W-1:0] upd_idx,
   input  logic [TAG_W-1:0]   upd_tag,
   input  line_st_t           upd_st,
   input  logic               upd_data_en,
   input  logic [DATA_W-1:0]  upd_data,
   input  logic [INDEX_W-1:0] a_idx,
   output logic [TAG_W-1:0]   a_tag,
   output line_st_t           a_st,
   output logic [DATA_W-1:0]  a_data,
   input  logic [INDEX_W-1:0] b_idx,
   output logic [TAG_W-1:0]   b_tag,
   output line_st_t           b_st,
   output logic [DATA_W-1:0]  b_data,
   output line_st_t           st_vec [LINES]
);
   logic [TAG_W-1:0]  tag_w  [LINES];
   logic [DATA_W-1:0] data_w [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      localparam logic [INDEX_W-1:0] MY_IDX = INDEX_W'(g);
      line_st_t          st_r;
      logic [TAG_W-1:0]  tag_r;
      logic [DATA_W-1:0] data_r;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_r   <= ST_INV;
            tag_r  <= '0;
            data_r <= '0;
         end else if (upd_en && upd_idx == MY_IDX) begin
            st_r  <= upd_st;
            tag_r <= upd_tag;
            if (upd_data_en) data_r <= upd_data;
         end
      end
      assign st_vec[g] = st_r;
      assign tag_w[g]  = tag_r;
      assign data_w[g] = data_r;
   end

   assign a_tag  = tag_w[a_idx];
   assign a_st   = st_vec[a_idx];
   assign a_data = data_w[a_idx];
   assign b_tag  = tag_w[b_idx];
   assign b_st   = st_vec[b_idx];
   assign b_data = data_w[b_idx];
endmodule

// File: rtl/snc_snoop.sv
module snc_snoop
   import snc_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int INDEX_W = 2,
   parameter int DATA_W  = 32,
   localparam int TAG_W  = ADDR_W - INDEX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               snp_valid,
   input  logic [1:0]         snp_cmd,
   input  logic [ADDR_W-1:0]  snp_addr,
   input  logic [TAG_W-1:0]   line_tag,
   input  line_st_t           line_st,
   input  logic [DATA_W-1:0]  line_data,
   output logic [INDEX_W-1:0] snp_idx,
   output logic               snp_hit,
   output logic               snp_supply,
   output logic               mem_abort,
   output logic [DATA_W-1:0]  snp_data,
   output logic               upd_en,
   output line_st_t           upd_st
);
   logic dirty_rd;

   assign snp_idx    = snp_addr[INDEX_W-1:0];
   assign snp_hit    = snp_valid && line_st != ST_INV
                       && line_tag == snp_addr[ADDR_W-1:INDEX_W];
   assign dirty_rd   = snp_hit && snp_cmd == CMD_RDMISS && line_st == ST_MOD;
   assign snp_supply = dirty_rd;
   assign mem_abort  = dirty_rd;
   assign snp_data   = dirty_rd ? line_data : '0;

   always_comb begin
      upd_en = 1'b0;
      upd_st = line_st;
      if (snp_hit && snp_cmd == CMD_INVAL) begin
         upd_en = 1'b1;
         upd_st = ST_INV;
      end else if (dirty_rd) begin
         upd_en = 1'b1;
         upd_st = ST_SHR;
      end
   end

   AST_ABORT_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_abort |-> snp_valid && snp_cmd == CMD_RDMISS) else $error("abort without read miss"); // R8
endmodule

// File: rtl/snc_cpu_ctrl.sv
module snc_cpu_ctrl
   import snc_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int INDEX_W = 2,
   parameter int DATA_W  = 32,
   localparam int TAG_W  = ADDR_W - INDEX_W
) (
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic [DATA_W-1:0]  cpu_rdata,
   output logic               cpu_ready,
   input  logic [TAG_W-1:0]   line_tag,
   input  line_st_t           line_st,
   input  logic [DATA_W-1:0]  line_data,
   input  logic               snp_busy,
   output logic               bus_req,
   input  logic               bus_gnt,
   output bus_cmd_t           bus_cmd,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [DATA_W-1:0]  bus_wdata,
   input  logic [DATA_W-1:0]  bus_rdata,
   output logic [INDEX_W-1:0] cpu_idx,
   output logic               upd_en,
   output logic [TAG_W-1:0]   upd_tag,
   output line_st_t           upd_st,
   output logic               upd_data_en,
   output logic [DATA_W-1:0]  upd_data
);
   logic [TAG_W-1:0] req_tag;
   logic             hit;
   logic             local_ok;

   assign cpu_idx  = cpu_addr[INDEX_W-1:0];
   assign req_tag  = cpu_addr[ADDR_W-1:INDEX_W];
   assign hit      = line_st != ST_INV && line_tag == req_tag;
   assign local_ok = hit && (!cpu_we || line_st == ST_MOD);

   always_comb begin
      cpu_ready   = 1'b0;
      cpu_rdata   = line_data;
      bus_req     = 1'b0;
      bus_cmd     = CMD_IDLE;
      bus_addr    = '0;
      bus_wdata   = '0;
      upd_en      = 1'b0;
      upd_tag     = line_tag;
      upd_st      = line_st;
      upd_data_en = 1'b0;
      upd_data    = cpu_wdata;
      if (cpu_req && local_ok) begin
         if (!snp_busy) begin
            cpu_ready = 1'b1;
            if (cpu_we) begin
               upd_en      = 1'b1;
               upd_st      = ST_MOD;
               upd_data_en = 1'b1;
            end
         end
      end else if (cpu_req) begin
         bus_req = 1'b1;
         if (hit) begin
            bus_cmd  = CMD_INVAL;
            bus_addr = cpu_addr;
         end else if (line_st == ST_MOD) begin
            bus_cmd   = CMD_WBACK;
            bus_addr  = {line_tag, cpu_idx};
            bus_wdata = line_data;
         end else begin
            bus_cmd  = CMD_RDMISS;
            bus_addr = cpu_addr;
         end
         if (bus_gnt) begin
            upd_en = 1'b1;
            unique case (bus_cmd)
               CMD_INVAL: begin
                  upd_st      = ST_MOD;
                  upd_data_en = 1'b1;
                  cpu_ready   = 1'b1;
               end
               CMD_WBACK: upd_st = ST_INV;
               default: begin
                  upd_st      = ST_SHR;
                  upd_tag     = req_tag;
                  upd_data_en = 1'b1;
                  upd_data    = bus_rdata;
                  cpu_ready   = !cpu_we;
                  cpu_rdata   = bus_rdata;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/snoop_cache.sv
module snoop_cache
   import snc_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int INDEX_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_supply,
   output logic [DATA_W-1:0] snp_data,
   output logic              mem_abort
);
   localparam int LINES = 1 << INDEX_W;
   localparam int TAG_W = ADDR_W - INDEX_W;

   if (INDEX_W < 1 || INDEX_W >= ADDR_W) begin : g_bad_index
      $error("INDEX_W must be at least 1 and below ADDR_W");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [INDEX_W-1:0] cpu_idx, snp_idx;
   logic [TAG_W-1:0]   a_tag, b_tag, c_tag;
   line_st_t           a_st, b_st, c_st, s_st, u_st;
   logic [DATA_W-1:0]  a_data, b_data, c_data;
   logic               c_en, c_den, s_en, snp_hit;
   line_st_t           st_vec [LINES];
   bus_cmd_t           cmd_e;

   logic               u_en, u_den;
   logic [INDEX_W-1:0] u_idx;
   logic [TAG_W-1:0]   u_tag;

   // snoop updates take priority; the CPU path is stalled in snoop cycles
   assign u_en  = s_en || c_en;
   assign u_idx = s_en ? snp_idx : cpu_idx;
   assign u_tag = s_en ? b_tag   : c_tag;
   assign u_st  = s_en ? s_st    : c_st;
   assign u_den = s_en ? 1'b0    : c_den;
   assign bus_cmd = cmd_e;

   snc_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
      .clk(clk), .rst_n(rst_n),
      .upd_en(u_en), .upd_idx(u_idx), .upd_tag(u_tag), .upd_st(u_st),
      .upd_data_en(u_den), .upd_data(c_data),
      .a_idx(cpu_idx), .a_tag(a_tag), .a_st(a_st), .a_data(a_data),
      .b_idx(snp_idx), .b_tag(b_tag), .b_st(b_st), .b_data(b_data),
      .st_vec(st_vec)
   );

   snc_snoop #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_snoop (
      .clk(clk), .rst_n(rst_n),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .line_tag(b_tag), .line_st(b_st), .line_data(b_data),
      .snp_idx(snp_idx), .snp_hit(snp_hit), .snp_supply(snp_supply),
      .mem_abort(mem_abort), .snp_data(snp_data),
      .upd_en(s_en), .upd_st(s_st)
   );

   snc_cpu_ctrl #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_ctrl (
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .line_tag(a_tag), .line_st(a_st), .line_data(a_data),
      .snp_busy(snp_valid),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(cmd_e),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cpu_idx(cpu_idx),
      .upd_en(c_en), .upd_tag(c_tag), .upd_st(c_st),
      .upd_data_en(c_den), .upd_data(c_data)
   );

   AST_SNOOP_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_hit && snp_cmd == CMD_INVAL) |=> st_vec[$past(snp_idx)] == ST_INV) else $error("invalidate ignored"); // R7
   AST_SUPPLY_TO_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |=> st_vec[$past(snp_idx)] == ST_SHR) else $error("supplier not shared"); // R8
   AST_WRITE_LEAVES_MOD: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && cpu_we) |=> st_vec[$past(cpu_idx)] == ST_MOD) else $error("write not modified"); // R3
   AST_FILL_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_gnt && bus_req && cmd_e == CMD_RDMISS) |=> st_vec[$past(cpu_idx)] == ST_SHR) else $error("fill not shared"); // R2
   AST_WBACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_gnt && bus_req && cmd_e == CMD_WBACK) |=> st_vec[$past(cpu_idx)] == ST_INV) else $error("victim kept"); // R6
   AST_NO_READY_IN_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !cpu_ready) else $error("cpu completed in snoop cycle"); // R12
endmodule

// File: tb/snoop_cache_test.sv
module snoop_cache_test;
   localparam int AW = 16;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
   logic cpu_ready, bus_req, bus_gnt;
   logic [1:0] bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata;
   logic snp_valid = 1'b0;
   logic [1:0] snp_cmd = '0;
   logic [AW-1:0] snp_addr = '0;
   logic snp_supply, mem_abort;
   logic [DW-1:0] snp_data;
   logic gnt_en = 1'b1;

   logic [DW-1:0] mem  [256];
   logic [DW-1:0] gold [256];
   logic [1:0]    log_cmd [$];
   logic [AW-1:0] log_adr [$];
   logic [DW-1:0] log_dat [$];
   logic [DW-1:0] exp_q [$];
   int log_ptr = 0;
   int checks = 0, fails = 0;
   int lat;

   always #2 clk = ~clk;

   snoop_cache uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .snp_supply(snp_supply), .snp_data(snp_data), .mem_abort(mem_abort)
   );

   assign bus_gnt   = bus_req & gnt_en & ~snp_valid;
   assign bus_rdata = mem[bus_addr[7:0]];

   task automatic chk(input bit ok, input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   // bus log: one entry per granted transaction
   always @(negedge clk) begin
      if (bus_gnt) begin
         log_cmd.push_back(bus_cmd);
         log_adr.push_back(bus_addr);
         log_dat.push_back(bus_wdata);
         if (bus_cmd == 2'b11) mem[bus_addr[7:0]] = bus_wdata;
      end
   end

   // monitor: compare completed reads against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && cpu_req && cpu_ready && !cpu_we) begin
         if (exp_q.size() == 0) chk(1'b0, "R2 unexpected read", cpu_rdata, '0);
         else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            chk(cpu_rdata == e, "R2 read data", cpu_rdata, e);
         end
      end
   end

   task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, output int cyc);
      @(posedge clk); #1;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      if (!we) exp_q.push_back(gold[a[7:0]]);
      cyc = 0;
      do begin @(negedge clk); cyc++; end while (!cpu_ready);
      @(posedge clk); #1;
      cpu_req = 1'b0;
      if (we) gold[a[7:0]] = d;
   endtask

   task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [DW-1:0] nv,
                        input bit exp_sup, input logic [DW-1:0] exp_d, input string r);
      @(posedge clk); #1;
      snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
      @(negedge clk);
      chk(snp_supply == exp_sup, r, DW'(snp_supply), DW'(exp_sup));
      chk(mem_abort == exp_sup, r, DW'(mem_abort), DW'(exp_sup));
      if (exp_sup) chk(snp_data == exp_d, r, snp_data, exp_d);
      if (cpu_req) chk(!cpu_ready, "R12 ready during snoop", DW'(cpu_ready), '0);
      @(posedge clk); #1;
      snp_valid = 1'b0;
      if (c == 2'b10) begin
         gold[a[7:0]] = nv;
         mem[a[7:0]]  = nv;
      end
   endtask

   task automatic exp_bus(input logic [1:0] c, input logic [AW-1:0] a, input string r);
      if (log_cmd.size() <= log_ptr) chk(1'b0, r, '0, DW'(c));
      else begin
         chk(log_cmd[log_ptr] == c, r, DW'(log_cmd[log_ptr]), DW'(c));
         chk(log_adr[log_ptr] == a, r, DW'(log_adr[log_ptr]), DW'(a));
         log_ptr++;
      end
   endtask

   task automatic no_more_bus(input string r);
      chk(log_cmd.size() == log_ptr, r, DW'(log_cmd.size()), DW'(log_ptr));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog expired", '0, '0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i]  = 32'hA000_0000 + i;
         gold[i] = 32'hA000_0000 + i;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!cpu_ready && !bus_req && !snp_supply && !mem_abort, "R1 idle outputs",
          {28'd0, cpu_ready, bus_req, snp_supply, mem_abort}, '0);

      // R1 R2: cold read misses, then hits
      cpu_op(1'b0, 16'h0010, '0, lat);
      exp_bus(2'b01, 16'h0010, "R1 cold miss");
      cpu_op(1'b0, 16'h0010, '0, lat);
      chk(lat == 1, "R2 read hit latency", DW'(lat), 1);
      no_more_bus("R2 hit uses no bus");

      // R3: write to Shared line invalidates
      cpu_op(1'b1, 16'h0010, 32'h1111_1111, lat);
      exp_bus(2'b10, 16'h0010, "R3 upgrade invalidate");
      // R4: write to Modified line stays local
      cpu_op(1'b1, 16'h0010, 32'h2222_2222, lat);
      chk(lat == 1, "R4 local write latency", DW'(lat), 1);
      no_more_bus("R4 no bus on modified write");
      cpu_op(1'b0, 16'h0010, '0, lat);

      // R8: dirty snoop supplies and aborts memory, line goes Shared
      snoop(2'b01, 16'h0010, '0, 1'b1, 32'h2222_2222, "R8 dirty supply");
      cpu_op(1'b1, 16'h0010, 32'h3333_3333, lat);
      exp_bus(2'b10, 16'h0010, "R8 shared after supply");
      snoop(2'b01, 16'h0010, '0, 1'b1, 32'h3333_3333, "R8 second supply");
      // R9: shared line does not supply
      snoop(2'b01, 16'h0010, '0, 1'b0, '0, "R9 shared no supply");

      // R10: same index, other tag
      snoop(2'b10, 16'h0014, 32'h9999_0014, 1'b0, '0, "R10 other tag");
      cpu_op(1'b0, 16'h0010, '0, lat);
      chk(lat == 1, "R10 line kept", DW'(lat), 1);
      no_more_bus("R10 no refetch");

      // R7: invalidation forces a fresh fetch
      snoop(2'b10, 16'h0010, 32'h4444_4444, 1'b0, '0, "R7 invalidate snoop");
      cpu_op(1'b0, 16'h0010, '0, lat);
      exp_bus(2'b01, 16'h0010, "R7 refetch after invalidate");

      // R5: write miss
      cpu_op(1'b1, 16'h0021, 32'h5555_5555, lat);
      exp_bus(2'b01, 16'h0021, "R5 write miss fetch");
      exp_bus(2'b10, 16'h0021, "R5 write miss invalidate");
      cpu_op(1'b0, 16'h0021, '0, lat);
      chk(lat == 1, "R5 written line hits", DW'(lat), 1);

      // R6: dirty victim written back first
      cpu_op(1'b0, 16'h0025, '0, lat);
      chk(log_dat[log_ptr] == 32'h5555_5555, "R6 writeback data", log_dat[log_ptr], 32'h5555_5555);
      exp_bus(2'b11, 16'h0021, "R6 writeback first");
      exp_bus(2'b01, 16'h0025, "R6 then read miss");
      chk(mem[8'h21] == 32'h5555_5555, "R6 memory updated", mem[8'h21], 32'h5555_5555);

      // R11: lost race on an upgrade
      cpu_op(1'b0, 16'h0032, '0, lat);
      exp_bus(2'b01, 16'h0032, "R11 setup fetch");
      gnt_en = 1'b0;
      fork
         cpu_op(1'b1, 16'h0032, 32'h6666_6666, lat);
         begin
            repeat (3) @(posedge clk);
            snoop(2'b10, 16'h0032, 32'h7777_7777, 1'b0, '0, "R11 winner invalidates");
            gnt_en = 1'b1;
         end
      join
      exp_bus(2'b01, 16'h0032, "R11 loser refetches");
      exp_bus(2'b10, 16'h0032, "R11 loser invalidates");
      cpu_op(1'b0, 16'h0032, '0, lat);
      chk(lat == 1, "R11 final hit", DW'(lat), 1);

      // R12: hit presented in a snoop cycle waits one cycle
      fork
         snoop(2'b01, 16'h0003, '0, 1'b0, '0, "R12 unrelated snoop");
         cpu_op(1'b0, 16'h0032, '0, lat);
      join
      chk(lat == 2, "R12 stalled hit latency", DW'(lat), 2);
      no_more_bus("R12 no bus");

      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R2 scoreboard drained", DW'(exp_q.size()), '0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule